// File: doc/BRIEF.md
# Triple-sample timer consistency filter

This block reads a free-running packed cycle-timer word that can be sampled with errors. It produces a 64-bit bus time that software or a DMA engine can trust. In strict mode, every attempt captures the timer three times, a programmable number of clock cycles apart. Each capture is turned into a linear tick count. The third capture is accepted only when both intervals between neighbouring captures are positive and neither interval is as large as twice the other. A failed attempt starts over from the first capture, and a saturating counter records how many attempts were thrown away.

In relaxed mode the block takes one capture and returns it unchecked. Use this mode when the timer source is known to update cleanly.

In both modes the result joins a 32-bit seconds value, in the upper half, with the accepted timer word, in the lower half. A one-cycle done pulse marks the result.

Top module: `tick_vote_filter`

## Requirements
- R1: After reset, `done_o` is 0, `retries_o` is 0 and `bus_time_o` is 0.
- R2: The linear tick value of a timer word is a sum of three fields, taken modulo 2^32:
  - bits [11:0] with weight 1;
  - bits [24:12] with weight 3072;
  - bits [31:25] with weight 24,576,000.

  On acceptance, `bus_time_o` becomes {`secs_i` at the accepting edge, third capture}. `bus_time_o` changes only in a cycle where `done_o` is high.
- R3: With `strict_i` high at the start edge E, let G be `gap_i` latched at E. The captures are taken at edges E+(G+1), E+2(G+1) and E+3(G+1). A first-attempt acceptance raises `done_o` right after edge E+3(G+1)+1, and each rejected attempt adds 3(G+1)+1 cycles.
- R4: An attempt is rejected, and restarted from the first capture, when either interval (t1−t0 or t2−t1, as signed 32-bit) is zero or negative.
- R5: An attempt is rejected when either interval is greater than or equal to twice the other.
- R6: With `strict_i` low at the start edge, one capture is taken at edge E+G+1 and returned unchecked. `done_o` rises right after edge E+G+2, and `retries_o` stays 0.
- R7: `retries_o` has these rules:
  - it is cleared when a start is accepted;
  - it increments once per rejected attempt and saturates at all ones (15);
  - it holds its value after done until the next start.
- R8: `done_o` is high for exactly one cycle. `start_i` is ignored unless the block is idle, including in the done cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new bus-time reading (taken only when idle) |
| timer_i | input | 32 | Packed cycle-timer word being sampled |
| strict_i | input | 1 | 1: triple capture with checks; 0: single unchecked capture |
| secs_i | input | 32 | Seconds value placed in the upper half of the result |
| gap_i | input | 8 | Capture spacing G; captures are G+1 cycles apart |
| bus_time_o | output | 64 | {seconds, accepted timer word} |
| done_o | output | 1 | One-cycle strobe when `bus_time_o` is fresh |
| retries_o | output | 4 | Saturating count of rejected attempts for the latest request |

## Verification
Two events can fall on the same clock cycle: a new start request and the done pulse of the previous one. The bench raises `start_i` exactly in the cycle where `done_o` is high, and once more in the middle of the sampling phase. It then judges by two things: the done pulse for the original request carries the predicted value, retry count and edge; and no further done pulse appears in the following cycles. A second pairing is also provoked by a timer frozen for about thirty attempts: a rejection arriving while the retry counter is already saturated. The bench then expects the count to stay at 15 rather than wrap.

// File: rtl/tvf_pkg.sv
package tvf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_S0    = 3'd1,
      ST_S1    = 3'd2,
      ST_S2    = 3'd3,
      ST_CHECK = 3'd4,
      ST_DONE  = 3'd5
   } seq_state_e;

   localparam int NUM_CAPTURES = 3;

endpackage

// File: rtl/tvf_linearize.sv
module tvf_linearize #(
   parameter int OFF_W    = 12,
   parameter int CNT_W    = 13,
   parameter int SEC_W    = 7,
   parameter int OFF_SPAN = 3072,
   parameter int CNT_SPAN = 8000,
   parameter int TW       = 32
) (
   input  logic [TW-1:0] word_i,
   output logic [TW-1:0] ticks_o
);

   localparam logic [TW-1:0] CNT_WT = TW'(OFF_SPAN);
   localparam logic [TW-1:0] SEC_WT = TW'(OFF_SPAN * CNT_SPAN);

   if (OFF_W + CNT_W + SEC_W != TW) begin : g_bad_fields
      $error("field widths must add up to the word width");
   end
   if (OFF_SPAN > (1 << OFF_W)) begin : g_bad_off
      $error("offset span does not fit the offset field");
   end
   if (CNT_SPAN > (1 << CNT_W)) begin : g_bad_cnt
      $error("count span does not fit the count field");
   end

   logic [OFF_W-1:0] off_f;
   logic [CNT_W-1:0] cnt_f;
   logic [SEC_W-1:0] sec_f;

   assign off_f = word_i[OFF_W-1:0];
   assign cnt_f = word_i[OFF_W +: CNT_W];
   assign sec_f = word_i[TW-1 -: SEC_W];

   assign ticks_o = TW'(off_f) + TW'(cnt_f) * CNT_WT + TW'(sec_f) * SEC_WT;

endmodule

// File: rtl/tvf_judge.sv
module tvf_judge #(
   parameter int TW    = 32,
   parameter int RATIO = 2
) (
   input  logic [TW-1:0] t0_i,
   input  logic [TW-1:0] t1_i,
   input  logic [TW-1:0] t2_i,
   output logic          ok_o
);

   localparam int  MW    = TW + $clog2(RATIO) + 1;
   localparam int  SH    = $clog2(RATIO);
   localparam bit  POW2  = ((RATIO & (RATIO - 1)) == 0);

   if (RATIO < 2) begin : g_bad_ratio
      $error("RATIO must be at least 2");
   end

   logic signed [TW-1:0] d01, d12;
   logic                 pos01, pos12;
   logic [MW-1:0]        a01, a12, s01, s12;
   logic                 big01, big12;

   assign d01   = $signed(t1_i - t0_i);
   assign d12   = $signed(t2_i - t1_i);
   assign pos01 = (d01 > 0);
   assign pos12 = (d12 > 0);
   assign a01   = MW'($unsigned(d01));
   assign a12   = MW'($unsigned(d12));

   if (POW2) begin : g_shift_scale
      assign s01 = a01 << SH;
      assign s12 = a12 << SH;
   end else begin : g_mult_scale
      assign s01 = a01 * MW'(RATIO);
      assign s12 = a12 * MW'(RATIO);
   end

   assign big01 = (a01 >= s12);
   assign big12 = (a12 >= s01);
   assign ok_o  = pos01 & pos12 & ~big01 & ~big12;

endmodule

// File: rtl/tvf_sequencer.sv
module tvf_sequencer
   import tvf_pkg::*;
#(
   parameter int TW    = 32,
   parameter int GAP_W = 8,
   parameter int RET_W = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start_i,
   input  logic                                strict_i,
   input  logic [GAP_W-1:0]                    gap_i,
   input  logic [TW-1:0]                       timer_i,
   input  logic                                verdict_i,
   output logic [NUM_CAPTURES-1:0][TW-1:0]     samp_o,
   output logic                                take_o,
   output logic                                done_o,
   output logic [RET_W-1:0]                    retries_o
);

   localparam logic [RET_W-1:0] RMAX = {RET_W{1'b1}};

   if (RET_W < 1 || GAP_W < 1) begin : g_bad_widths
      $error("counter widths must be positive");
   end

   seq_state_e        st_q;
   logic [GAP_W-1:0]  gap_q, wait_q;
   logic              strict_q;
   logic [RET_W-1:0]  ret_q;
   logic              lap;

   assign lap    = (wait_q == gap_q);
   assign take_o = (st_q == ST_CHECK) && (verdict_i || !strict_q);

   // capture slots, one per sampling state
   for (genvar k = 0; k < NUM_CAPTURES; k++) begin : g_slot
      localparam logic [2:0] SLOT = 3'(1 + k);
      logic hit;
      assign hit = (st_q == seq_state_e'(SLOT)) && lap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   samp_o[k] <= '0;
         else if (hit) samp_o[k] <= timer_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         gap_q    <= '0;
         wait_q   <= '0;
         strict_q <= 1'b0;
         ret_q    <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  strict_q <= strict_i;
                  gap_q    <= gap_i;
                  ret_q    <= '0;
                  wait_q   <= '0;
                  st_q     <= strict_i ? ST_S0 : ST_S2;
               end
            end
            ST_S0, ST_S1, ST_S2: begin
               if (lap) begin
                  wait_q <= '0;
                  case (st_q)
                     ST_S0:   st_q <= ST_S1;
                     ST_S1:   st_q <= ST_S2;
                     default: st_q <= ST_CHECK;
                  endcase
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            ST_CHECK: begin
               wait_q <= '0;
               if (take_o) begin
                  st_q <= ST_DONE;
               end else begin
                  st_q <= ST_S0;
                  if (ret_q != RMAX) ret_q <= ret_q + 1'b1;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o    = (st_q == ST_DONE);
   assign retries_o = ret_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   retry_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_q == RMAX && st_q != ST_IDLE) |=> (ret_q == RMAX));

   // R4
   retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CHECK && !take_o && ret_q != RMAX) |=> (ret_q == $past(ret_q) + 1'b1));

   // R6
   single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && start_i && !strict_i) |=> (st_q == ST_S2 && wait_q == '0));

   // R3
   gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q inside {ST_S0, ST_S1, ST_S2}) |-> (wait_q <= gap_q));

endmodule

// File: rtl/tick_vote_filter.sv
module tick_vote_filter
   import tvf_pkg::*;
#(
   parameter int OFF_W    = 12,
   parameter int CNT_W    = 13,
   parameter int SEC_W    = 7,
   parameter int OFF_SPAN = 3072,
   parameter int CNT_SPAN = 8000,
   parameter int SECS_W   = 32,
   parameter int GAP_W    = 8,
   parameter int RET_W    = 4,
   parameter int RATIO    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start_i,
   input  logic [OFF_W+CNT_W+SEC_W-1:0]      timer_i,
   input  logic                              strict_i,
   input  logic [SECS_W-1:0]                 secs_i,
   input  logic [GAP_W-1:0]                  gap_i,
   output logic [SECS_W+OFF_W+CNT_W+SEC_W-1:0] bus_time_o,
   output logic                              done_o,
   output logic [RET_W-1:0]                  retries_o
);

   localparam int TW = OFF_W + CNT_W + SEC_W;
   localparam int BW = SECS_W + TW;

   logic [NUM_CAPTURES-1:0][TW-1:0] samp;
   logic [NUM_CAPTURES-1:0][TW-1:0] lin;
   logic                            verdict;
   logic                            take;
   logic [BW-1:0]                   bt_q;

   tvf_sequencer #(
      .TW    (TW),
      .GAP_W (GAP_W),
      .RET_W (RET_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .strict_i  (strict_i),
      .gap_i     (gap_i),
      .timer_i   (timer_i),
      .verdict_i (verdict),
      .samp_o    (samp),
      .take_o    (take),
      .done_o    (done_o),
      .retries_o (retries_o)
   );

   for (genvar k = 0; k < NUM_CAPTURES; k++) begin : g_lin
      tvf_linearize #(
         .OFF_W    (OFF_W),
         .CNT_W    (CNT_W),
         .SEC_W    (SEC_W),
         .OFF_SPAN (OFF_SPAN),
         .CNT_SPAN (CNT_SPAN),
         .TW       (TW)
      ) u_lin (
         .word_i  (samp[k]),
         .ticks_o (lin[k])
      );
   end

   tvf_judge #(
      .TW    (TW),
      .RATIO (RATIO)
   ) u_judge (
      .t0_i (lin[0]),
      .t1_i (lin[1]),
      .t2_i (lin[2]),
      .ok_o (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bt_q <= '0;
      else if (take) bt_q <= {secs_i, samp[NUM_CAPTURES-1]};
   end

   assign bus_time_o = bt_q;

   // R2
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_time_o) |-> done_o);

endmodule

// File: tb/tick_vote_filter_test.sv
module tick_vote_filter_test;

   localparam int GW = 8;
   localparam int RW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          strict = 1'b0;
   logic [31:0]   timer = '0;
   logic [31:0]   secs = '0;
   logic [GW-1:0] gap = '0;
   wire  [63:0]   bus_time;
   wire           done;
   wire  [RW-1:0] retries;

   tick_vote_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .timer_i    (timer),
      .strict_i   (strict),
      .secs_i     (secs),
      .gap_i      (gap),
      .bus_time_o (bus_time),
      .done_o     (done),
      .retries_o  (retries)
   );

   always #5 clk = ~clk;

   int n = 0;
   always @(posedge clk) n <= n + 1;

   // timer stream knobs (absolute edge indices)
   longint      base = 0, step = 1, jamt = 0;
   int          org = 0, jn = 1 << 30, flo = -10, fhi = -20, gln = -1;
   logic [31:0] glx = '0;
   // relative knobs set by scenarios
   int          rjn = -1, rflo = -1, rfhi = -1, rgl = -1;

   int nchk = 0, nbad = 0, ndone = 0;

   logic [63:0] qw[$];
   int          qr[$];
   int          qe[$];
   string       qt[$];

   function automatic logic [31:0] pack(input longint t);
      longint s, r, c, o;
      s = t / 24576000;
      r = t % 24576000;
      c = r / 3072;
      o = r % 3072;
      return {s[6:0], c[12:0], o[11:0]};
   endfunction

   function automatic logic [31:0] lin(input logic [31:0] w);
      longint a, b, c, v;
      a = w[11:0];
      b = w[24:12];
      c = w[31:25];
      v = a + 3072 * b + 24576000 * c;
      return v[31:0];
   endfunction

   function automatic logic [31:0] tval(input int nn);
      int          m;
      longint      t;
      logic [31:0] w;
      m = (nn >= flo && nn <= fhi) ? flo : nn;
      t = base + step * longint'(m - org) + ((m >= jn) ? jamt : 0);
      w = pack(t);
      if (nn == gln) w = w ^ glx;
      return w;
   endfunction

   always @(negedge clk) timer = tval(n + 1);

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic model(input int e0, input int g, input bit st,
                        output logic [31:0] w, output int r, output int de);
      r = 0;
      w = '0;
      de = -1;
      if (!st) begin
         w  = tval(e0 + g + 1);
         de = e0 + g + 2;
      end else begin
         int ea;
         ea = e0;
         for (int a = 0; a < 5000; a++) begin
            logic [31:0] s0, s1, s2;
            int          d01, d12;
            bit          good;
            s0 = tval(ea + (g + 1));
            s1 = tval(ea + 2 * (g + 1));
            s2 = tval(ea + 3 * (g + 1));
            d01 = $signed(lin(s1) - lin(s0));
            d12 = $signed(lin(s2) - lin(s1));
            good = (d01 > 0) && (d12 > 0) && ((d01 / d12) < 2) && ((d12 / d01) < 2);
            if (good) begin
               w  = s2;
               de = ea + 3 * (g + 1) + 1;
               break;
            end
            if (r < 15) r++;
            ea = ea + 3 * (g + 1) + 1;
         end
      end
   endtask

   task automatic clear_knobs();
      base = 1000000; step = 7; jamt = 0;
      rjn = -1; rflo = -1; rfhi = -1; rgl = -1; glx = '0;
   endtask

   // driver: predicts the result and pushes it to the scoreboard
   task automatic launch(input int g, input bit st, input logic [31:0] sc,
                         input string tag, input bit poke);
      int          e0, r, de;
      logic [31:0] w;
      @(negedge clk);
      e0  = n + 2;
      org = e0;
      gln = (rgl < 0) ? -1 : e0 + rgl;
      jn  = (rjn < 0) ? (1 << 30) : e0 + rjn;
      flo = (rflo < 0) ? -10 : e0 + rflo;
      fhi = (rflo < 0) ? -20 : e0 + rfhi;
      gap    = GW'(g);
      strict = st;
      secs   = sc;
      @(negedge clk);
      model(e0, g, st, w, r, de);
      qw.push_back({sc, w});
      qr.push_back(r);
      qe.push_back(de);
      qt.push_back(tag);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         while (n < e0 + 3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (n < de) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (qw.size() > 0) @(negedge clk);
      repeat (poke ? 40 : 4) @(negedge clk);
   endtask

   // monitor: pops and compares on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         ndone++;
         if (qw.size() == 0) begin
            chk(1'b0, "R8 unexpected done pulse", 64'd1, 64'd0);
         end else begin
            logic [63:0] ew;
            int          er, ee;
            string       tg;
            ew = qw.pop_front();
            er = qr.pop_front();
            ee = qe.pop_front();
            tg = qt.pop_front();
            chk(bus_time == ew, {tg, " R2 bus time"}, bus_time, ew);
            chk(int'(retries) == er, {tg, " R7 retry count"}, 64'(retries), 64'(er));
            chk(n == ee, {tg, " R3 done edge"}, 64'(n), 64'(ee));
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      summary();
      $finish;
   end

   initial begin
      int d0;
      clear_knobs();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
      chk(retries == '0, "R1 retries after reset", 64'(retries), 64'd0);
      chk(bus_time == '0, "R1 bus time after reset", bus_time, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done == 1'b0 && bus_time == '0, "R1 idle after release", bus_time, 64'd0);

      // R2 seconds-field wrap inside the attempt
      clear_knobs(); base = 64'd24576000 * 6 - 60; step = 7;
      launch(2, 1'b1, 32'h1234_5678, "R2 sec-wrap", 1'b0);
      // R2 count-field wrap
      clear_knobs(); base = 3072 * 100 + 3040; step = 11;
      launch(1, 1'b1, 32'h0000_0042, "R2 cnt-wrap", 1'b0);
      // R5 late interval too long
      clear_knobs(); rjn = 9; jamt = 500;
      launch(2, 1'b1, 32'hA5A5_0001, "R5 long-second", 1'b0);
      // R5 early interval too long
      clear_knobs(); rjn = 6; jamt = 500;
      launch(2, 1'b1, 32'hA5A5_0002, "R5 long-first", 1'b0);
      // R4 zero interval (stalled count)
      clear_knobs(); rflo = 6; rfhi = 9;
      launch(2, 1'b1, 32'h0000_0100, "R4 zero-interval", 1'b0);
      // R4 negative interval
      clear_knobs(); rjn = 9; jamt = -100;
      launch(2, 1'b1, 32'h0000_0200, "R4 negative", 1'b0);
      // R4 garbage in low bits of a middle capture
      clear_knobs(); rgl = 6; glx = 32'h0000_03FF;
      launch(2, 1'b1, 32'h0000_0300, "R4 garbage-low", 1'b0);
      // R6 relaxed mode returns a corrupted single capture unchecked
      clear_knobs(); rgl = 4; glx = 32'h0000_03FF;
      launch(3, 1'b0, 32'h0000_0400, "R6 relaxed", 1'b0);
      // R6 relaxed mode with a frozen timer still completes at once
      clear_knobs(); rflo = 0; rfhi = 100;
      launch(0, 1'b0, 32'h0000_0401, "R6 relaxed-frozen", 1'b0);
      // R7 saturation under a long freeze
      clear_knobs(); base = 5000000; step = 11; rflo = 0; rfhi = 220;
      launch(1, 1'b1, 32'h0000_0500, "R7 saturate", 1'b0);
      chk(retries == 4'hF, "R7 retries held after done", 64'(retries), 64'hF);
      // R3 wide gap, R8 start during sampling and during done
      clear_knobs(); base = 77777; step = 2;
      d0 = ndone;
      launch(10, 1'b1, 32'h0000_0600, "R8 busy-start", 1'b1);
      chk(ndone == d0 + 1, "R8 single done for poked run", 64'(ndone), 64'(d0 + 1));
      chk(retries == '0, "R8 retries untouched by ignored start", 64'(retries), 64'd0);

      summary();
      $finish;
   end

endmodule